// File: doc/BRIEF.md
# ESF Remote Alarm Pattern Generator

This block produces the remote alarm indication (yellow alarm) for the transmit side of a T1 framer. In extended-superframe operation it takes over the 4 kbit/s facility data link and sends a repeating 16-bit word: eight ones followed by eight zeros. The framer supplies a strobe once per data-link bit slot. The block presents the current alarm bit on `dl_bit` and raises `dl_own` to tell the framer that the alarm pattern owns the link. A host control bit, `esf_req`, requests the alarm.

A rising edge of the request starts a burst. The burst always carries at least `MIN_REPS` complete words; the default of 255 words lasts about one second. It also runs for as long as the request stays high, and it only stops at a word boundary. A new request may follow the end of a burst in the very next cycle, because no minimum gap is kept between bursts. A rising edge that arrives during a burst restarts the repeat count.

In superframe operation (`sf_mode` high) the alarm takes a different form. While its own request `sf_req` is high, the block raises `sf_bit2_zero` to tell the framer to clear bit 2 of every channel octet.

The controller has four states:
- `ST_IDLE`: nothing is sent.
- `ST_BURST_MIN`: the guaranteed minimum of words is being sent.
- `ST_BURST_HOLD`: the burst is being extended because the request is still high.
- `ST_SF_FORCE`: the superframe bit-2 alarm is active.

Its transitions are:
- IDLE→BURST_MIN on a request edge while `sf_mode` is low.
- IDLE→SF_FORCE when `sf_mode` and `sf_req` are both high.
- BURST_MIN→BURST_MIN on a request edge, which clears the count.
- BURST_MIN→BURST_HOLD at the last minimum word boundary if the request is high.
- BURST_MIN→IDLE at that same boundary if the request is low.
- BURST_HOLD→BURST_MIN on a request edge.
- BURST_HOLD→IDLE at a word boundary with the request low.
- SF_FORCE→IDLE when `sf_mode` or `sf_req` drops.

Top module: `esf_yellow_gen`

## Requirements
- R1: While `dl_own` is high, `dl_bit` carries the word LSB-first, one bit per accepted strobe: word bits 0..7 are 1 and bits 8..15 are 0. The first bit of a burst is word bit 0. While `dl_own` is low, `dl_bit` is 0.
- R2: Suppose the request is released after D strobes of a burst, with D < 16·MIN_REPS. Then the burst carries exactly 16·MIN_REPS bits.
- R3: Suppose the request is still high on strobe number D and low after it, with D ≥ 16·MIN_REPS. Then the burst carries 16·(⌊D/16⌋+1) bits.
- R4: `dl_own` falls only in the cycle after a strobe that carried word bit 15.
- R5: With `sf_mode` low and the block idle, a rising edge of `esf_req` raises `dl_own` on the next clock edge, however recently the previous burst ended.
- R6: A rising edge of `esf_req` during a burst lets the word in progress finish. The burst then sends exactly MIN_REPS further words (more if the request is held, per R3).
- R7: With `sf_mode` high and the block idle, `sf_req` high raises `sf_bit2_zero` one clock later. `sf_bit2_zero` falls one clock after `sf_req` or `sf_mode` goes low. `esf_req` does not start a burst while `sf_mode` is high, and `sf_req` has no effect while `sf_mode` is low.
- R8: After reset, `dl_own`, `dl_bit`, `sf_bit2_zero` and `alarm_active` are all 0.
- R9: `alarm_active` is high exactly when `dl_own` or `sf_bit2_zero` is high.
- R10: Cycles without a strobe neither advance the word position nor change `dl_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_strobe | input | 1 | One-cycle pulse per data-link bit slot; consumes the current `dl_bit` |
| sf_mode | input | 1 | 1 = superframe operation, 0 = extended superframe |
| esf_req | input | 1 | Host request for the data-link alarm (level, edge starts a burst) |
| sf_req | input | 1 | Host request for the superframe bit-2 alarm |
| dl_bit | output | 1 | Alarm bit for the current data-link slot |
| dl_own | output | 1 | Alarm pattern owns the data link |
| sf_bit2_zero | output | 1 | Framer must clear bit 2 of every channel octet |
| alarm_active | output | 1 | Some form of the alarm is being sent |

## Verification
The assertions assume three things about the inputs. `dl_strobe` is a synchronous single-cycle pulse. The host changes `esf_req` and `sf_mode` only at clock-synchronous points. `sf_mode` does not rise in the middle of a burst. The bench keeps to all three. It drives every input on the falling clock edge. It places strobes in every other cycle, never back to back. It switches framing mode only while the block is idle. Within these limits it sweeps the release point D across every value up to 40 bits beyond the minimum burst, with a small `MIN_REPS`. It also places restart edges both mid-word and on a word boundary.

// File: rtl/yalm_pkg.sv
package yalm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_BURST_MIN  = 2'd1,
        ST_BURST_HOLD = 2'd2,
        ST_SF_FORCE   = 2'd3
    } yalm_state_e;

endpackage

// File: rtl/yalm_pattern_seq.sv
module yalm_pattern_seq #(
    parameter int PAT_LEN  = 16,
    parameter int ONES_LEN = 8,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] idx_nxt,
    output logic             bit_val,
    output logic             last
);

    logic [IDX_W-1:0] idx_q;

    assign last    = (idx_q == IDX_W'(PAT_LEN - 1));
    assign bit_val = (idx_q < IDX_W'(ONES_LEN));
    assign idx     = idx_q;

    always_comb begin
        idx_nxt = idx_q;
        if (advance) begin
            idx_nxt = last ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_nxt;
        end
    end

endmodule

// File: rtl/esf_yellow_gen.sv
module esf_yellow_gen
    import yalm_pkg::*;
#(
    parameter int PAT_LEN  = 16,
    parameter int ONES_LEN = 8,
    parameter int MIN_REPS = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dl_strobe,
    input  logic sf_mode,
    input  logic esf_req,
    input  logic sf_req,
    output logic dl_bit,
    output logic dl_own,
    output logic sf_bit2_zero,
    output logic alarm_active
);

    localparam int IDX_W    = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
    localparam int REP_W    = (MIN_REPS > 1) ? $clog2(MIN_REPS) : 1;
    localparam int LAST_REP = MIN_REPS - 1;

    yalm_state_e      state_q, state_d;
    logic [REP_W-1:0] rep_q, rep_d;
    logic             skip_q, skip_d;
    logic             req_q;
    logic             req_edge;
    logic             sending;
    logic             advance;
    logic             wrap;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] idx_nxt;
    logic             bit_val;
    logic             last;

    assign req_edge = esf_req & ~req_q;
    assign sending  = (state_q == ST_BURST_MIN) || (state_q == ST_BURST_HOLD);
    assign advance  = sending & dl_strobe;
    assign wrap     = advance & last;

    yalm_pattern_seq #(
        .PAT_LEN  (PAT_LEN),
        .ONES_LEN (ONES_LEN),
        .IDX_W    (IDX_W)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .idx     (bit_idx),
        .idx_nxt (idx_nxt),
        .bit_val (bit_val),
        .last    (last)
    );

    // Next-state logic: word boundaries are the only exit points of a burst.
    always_comb begin
        state_d = state_q;
        rep_d   = rep_q;
        skip_d  = skip_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sf_mode && sf_req) begin
                    state_d = ST_SF_FORCE;
                end else if (!sf_mode && req_edge) begin
                    state_d = ST_BURST_MIN;
                    rep_d   = '0;
                    skip_d  = 1'b0;
                end
            end
            ST_BURST_MIN: begin
                if (req_edge) begin
                    rep_d  = '0;
                    skip_d = (idx_nxt != '0);
                end else if (wrap) begin
                    if (skip_q) begin
                        skip_d = 1'b0;
                    end else if (rep_q == REP_W'(LAST_REP)) begin
                        state_d = esf_req ? ST_BURST_HOLD : ST_IDLE;
                    end else begin
                        rep_d = rep_q + 1'b1;
                    end
                end
            end
            ST_BURST_HOLD: begin
                if (req_edge) begin
                    state_d = ST_BURST_MIN;
                    rep_d   = '0;
                    skip_d  = (idx_nxt != '0);
                end else if (wrap && !esf_req) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SF_FORCE: begin
                if (!sf_mode || !sf_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rep_q   <= '0;
            skip_q  <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rep_q   <= rep_d;
            skip_q  <= skip_d;
            req_q   <= esf_req;
        end
    end

    // Output decode.
    always_comb begin
        dl_own       = 1'b0;
        dl_bit       = 1'b0;
        sf_bit2_zero = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BURST_MIN, ST_BURST_HOLD: begin
                dl_own = 1'b1;
                dl_bit = bit_val;
            end
            ST_SF_FORCE: sf_bit2_zero = 1'b1;
            default: ;
        endcase
        alarm_active = dl_own | sf_bit2_zero;
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_own && !dl_strobe) |=> $stable(bit_idx)); // R10

    AST_WHOLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dl_own) |-> ($past(dl_strobe) && $past(bit_idx) == IDX_W'(PAT_LEN - 1))); // R4

    AST_MIN_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dl_own) |-> ($past(rep_q) == REP_W'(LAST_REP) && !$past(skip_q))); // R2

    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!dl_own && !sf_bit2_zero && !sf_mode && esf_req && !$past(esf_req)) |=> dl_own); // R5

    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_own) |-> !$past(sf_mode)); // R7

    AST_FORCE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        sf_bit2_zero |-> (!dl_own && !dl_bit)); // R7

endmodule

// File: tb/esf_yellow_gen_tb_top.sv
module esf_yellow_gen_tb_top;

    localparam int M    = 3;
    localparam int WORD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dl_strobe = 1'b0;
    logic sf_mode = 1'b0;
    logic esf_req = 1'b0;
    logic sf_req = 1'b0;
    logic dl_bit, dl_own, sf_bit2_zero, alarm_active;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    esf_yellow_gen #(.PAT_LEN(WORD), .ONES_LEN(8), .MIN_REPS(M)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dl_strobe    (dl_strobe),
        .sf_mode      (sf_mode),
        .esf_req      (esf_req),
        .sf_req       (sf_req),
        .dl_bit       (dl_bit),
        .dl_own       (dl_own),
        .sf_bit2_zero (sf_bit2_zero),
        .alarm_active (alarm_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One strobe cycle then one quiet cycle; returns the bit carried.
    task automatic strobe_once(output logic b, output logic own);
        @(negedge clk);
        dl_strobe = 1'b1;
        #1;
        b   = dl_bit;
        own = dl_own;
        @(negedge clk);
        dl_strobe = 1'b0;
    endtask

    // Runs strobes until dl_own falls; drops esf_req after strobe drop_at.
    task automatic run_out(input int start_cnt, input int drop_at,
                           inout int cnt, inout int bad);
        logic b, own;
        cnt = start_cnt;
        while (dl_own && cnt < 2000) begin
            strobe_once(b, own);
            if (b != ((cnt % WORD) < 8)) bad++;
            cnt++;
            if (cnt == drop_at) esf_req = 1'b0;
            #1;
            if (!dl_own && (cnt % WORD) != 0) bad++; // R4 word boundary
            if (alarm_active != (dl_own | sf_bit2_zero)) bad++; // R9
        end
        esf_req = 1'b0;
    endtask

    initial begin
        int cnt, bad, expv;
        logic b, own, held;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 dl_own", dl_own, 0);
        chk("R8 dl_bit", dl_bit, 0);
        chk("R8 sf_bit2_zero", sf_bit2_zero, 0);
        chk("R8 alarm_active", alarm_active, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R1/R5 sweep of release point, bursts back to back
        for (int d = 1; d <= WORD * M + 40; d++) begin
            esf_req = 1'b1;
            @(negedge clk);
            chk($sformatf("R5 start d=%0d", d), dl_own, 1);
            chk($sformatf("R9 active d=%0d", d), alarm_active, 1);
            bad = 0;
            run_out(0, d, cnt, bad);
            expv = (d < WORD * M) ? WORD * M : WORD * (d / WORD + 1);
            chk($sformatf("%s length d=%0d", (d < WORD * M) ? "R2" : "R3", d), cnt, expv);
            chk($sformatf("R1 pattern/R4/R9 d=%0d", d), bad, 0);
            chk($sformatf("R1 idle bit d=%0d", d), dl_bit, 0);
        end

        // R6 and R10: restart mid-word, with strobe gaps
        esf_req = 1'b1;
        @(negedge clk);
        esf_req = 1'b0;
        bad = 0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            strobe_once(b, own);
            if (b != ((cnt % WORD) < 8)) bad++;
            cnt++;
        end
        held = dl_bit;
        repeat (5) @(negedge clk);
        chk("R10 dl_bit stable", dl_bit, held);
        chk("R10 dl_own kept", dl_own, 1);
        esf_req = 1'b1;
        @(negedge clk);
        esf_req = 1'b0;
        run_out(cnt, -1, cnt, bad);
        chk("R6 restart mid-word length", cnt, 2 * WORD + WORD * M);
        chk("R6 restart mid-word pattern", bad, 0);

        // R6 restart exactly on word boundary
        @(negedge clk);
        esf_req = 1'b1;
        @(negedge clk);
        esf_req = 1'b0;
        bad = 0;
        cnt = 0;
        for (int i = 0; i < WORD; i++) begin
            strobe_once(b, own);
            cnt++;
        end
        esf_req = 1'b1;
        @(negedge clk);
        esf_req = 1'b0;
        run_out(cnt, -1, cnt, bad);
        chk("R6 restart at boundary length", cnt, WORD + WORD * M);

        // R7 superframe alarm
        @(negedge clk);
        sf_mode = 1'b1;
        @(negedge clk);
        sf_req = 1'b1;
        @(negedge clk);
        chk("R7 force raised", sf_bit2_zero, 1);
        chk("R9 active in SF", alarm_active, 1);
        chk("R7 no data-link own", dl_own, 0);
        sf_req = 1'b0;
        @(negedge clk);
        chk("R7 force dropped", sf_bit2_zero, 0);
        chk("R9 inactive", alarm_active, 0);
        esf_req = 1'b1;
        @(negedge clk);
        strobe_once(b, own);
        chk("R7 esf_req ignored in SF", dl_own, 0);
        esf_req = 1'b0;
        sf_req = 1'b1;
        @(negedge clk);
        sf_mode = 1'b0;
        @(negedge clk);
        chk("R7 force drops with mode", sf_bit2_zero, 0);
        repeat (3) @(negedge clk);
        chk("R7 sf_req ignored in ESF", sf_bit2_zero, 0);
        sf_req = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule